// File: doc/BRIEF.md
# Machine-Cycle Bus Timing Sequencer

This block runs the external bus side of one processor machine cycle. A cycle request enters through a valid/ready handshake. It carries a cycle type, an address and write data. The sequencer then steps through the clock states T1, T2, zero or more wait states TW, and T3. Along the way it drives the address bus, a status byte, the read strobe (`dbin`), the active-low write strobe (`wr_n`), the sync marker and the wait indicator. Each clock state lasts exactly one clock of the single clock.

The handshake rules are:
- A request is taken on a rising edge where both `req_valid` and `req_ready` are high.
- `req_ready` is high only when the sequencer is idle, or when it is in the hold state and `hold` has just been released.
- The requester must keep the request stable until it is taken.
- Read data comes back as a one-clock `rd_valid` pulse during T3. It has no back-pressure.

The block also arbitrates bus ownership with `hold`/`hlda`, so that an external master can take over the address and data buses. Each bus is modelled as separate output, output-enable and input signals.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, the outputs are at rest: `hlda`=0, `sync`=0, `dbin`=0, `wr_n`=1, `wait_st`=0, `data_oe`=0, `rd_valid`=0 and `req_ready`=1.
- R2: The clock after a request is accepted is T1. In T1, `sync`=1, `data_oe`=1 and `data_out` holds the status byte for the cycle type. The type codes and their status bytes are:
  - 0 fetch: A2
  - 1 memory read: 82
  - 2 memory write: 00
  - 3 input: 42
  - 4 output: 10
  - 5 interrupt acknowledge: 23
  - 6 and 7: treated as a memory read
- R3: Types 0, 1, 3, 5, 6 and 7 are reads.
  - `dbin`=1 in T2 and in every TW, with `data_oe`=0.
  - `data_in` is sampled on the edge that leaves T2/TW with `ready` high.
  - `rd_valid`=1 with that byte on `rd_data` for one clock, during T3.
- R4: Types 2 and 4 are writes. `wr_n`=0 from T2 through T3. Over that whole span, `data_oe`=1 and `data_out` holds the request's write data without change.
- R5: The sequencer leaves T2 or TW for T3 only on an edge where `ready` is high. Otherwise it goes to TW, with `wait_st`=1, for one clock per low-`ready` edge.
- R6: `addr_out` is driven with `addr_oe`=1 from T1 through T3.
  - For memory cycles it holds the request address.
  - For input/output cycles it holds the 8-bit port number (address bits 7:0) in both the upper and the lower byte.
- R7: `hold` is recognized only in two cases:
  - on an edge leaving T2/TW with `ready` high;
  - while idle with `halt` high.
  When idle and not halted, `hold` leaves `hlda`=0 and `req_ready`=1.
- R8: When `hold` is recognized during a read cycle, `hlda` rises in T3. During a write cycle it rises in the clock after T3. When idle and halted, it rises in the next clock.
- R9: From the clock after `hlda` rises, and for as long as it stays high, `addr_oe`=0 and `data_oe`=0.
- R10: When `hold` is low in the hold state, the next clock has `hlda`=0. If a request was taken on that edge, that next clock is T1 of the new cycle.
- R11: `rst` clears `hlda` and returns the buses to the idle state, even during a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each clock state lasts one period |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Cycle request present |
| req_ready | output | 1 | Cycle request can be taken this edge |
| req_type | input | 3 | Cycle type code (see R2) |
| req_addr | input | 16 | Memory address, or port number in bits 7:0 |
| req_wdata | input | 8 | Write data for write cycles |
| ready | input | 1 | Memory/I/O ready; low extends the cycle |
| hold | input | 1 | External bus master requests the buses |
| halt | input | 1 | Processor is halted |
| addr_out | output | 16 | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| data_out | output | 8 | Data bus value (status byte or write data) |
| data_oe | output | 1 | Data bus drive enable |
| data_in | input | 8 | Data bus input value |
| sync | output | 1 | High during T1 |
| dbin | output | 1 | Data bus in input mode |
| wr_n | output | 1 | Write strobe, active low |
| wait_st | output | 1 | High in a wait state |
| hlda | output | 1 | Hold acknowledge |
| rd_valid | output | 1 | Read data valid (T3 of a read) |
| rd_data | output | 8 | Captured read data |

## Verification
The latencies are fixed:
- T1 appears one clock after the accepting edge.
- T2 follows T1 by one clock.
- Each low-`ready` edge adds exactly one TW clock.
- T3 and `rd_valid` follow the first high-`ready` edge by one clock.
- `hlda` appears in T3 for reads, and one clock later for writes and halted grants.
- The buses float one clock after `hlda` rises.

All inputs are driven on the falling edge, and all outputs are sampled on the falling edge. A driver task therefore counts falling edges from acceptance to reach each state. A scoreboard monitor pairs every `sync` clock with the next queued request, to check the status byte and address. It checks the write data while `wr_n` is low and the read byte when `rd_valid` pulses.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_T1    = 3'd1,
    ST_T2    = 3'd2,
    ST_TW    = 3'd3,
    ST_T3    = 3'd4,
    ST_GRANT = 3'd5,
    ST_HOLD  = 3'd6
  } seq_state_t;

  localparam logic [2:0] CYC_FETCH = 3'd0;
  localparam logic [2:0] CYC_MRD   = 3'd1;
  localparam logic [2:0] CYC_MWR   = 3'd2;
  localparam logic [2:0] CYC_IN    = 3'd3;
  localparam logic [2:0] CYC_OUT   = 3'd4;
  localparam logic [2:0] CYC_INTA  = 3'd5;

  function automatic logic cyc_is_write(input logic [2:0] t);
    return (t == CYC_MWR) || (t == CYC_OUT);
  endfunction

  function automatic logic cyc_is_io(input logic [2:0] t);
    return (t == CYC_IN) || (t == CYC_OUT);
  endfunction

endpackage

// File: rtl/bus_seq_latch.sv
module bus_seq_latch
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [2:0]        cur_type,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata
);
  localparam int REP = ADDR_W / PORT_W;

  logic [ADDR_W-1:0] io_addr;

  // Port number is mirrored into every byte lane of the address bus.
  generate
    for (genvar g = 0; g < REP; g++) begin : g_port_lane
      assign io_addr[g*PORT_W +: PORT_W] = req_addr[PORT_W-1:0];
    end
    if (REP * PORT_W < ADDR_W) begin : g_pad
      assign io_addr[ADDR_W-1:REP*PORT_W] = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_type  <= CYC_FETCH;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_type  <= req_type;
      cur_addr  <= cyc_is_io(req_type) ? io_addr : req_addr;
      cur_wdata <= req_wdata;
    end
  end

endmodule

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       cur_write,
  input  logic       ready,
  input  logic       hold,
  input  logic       halt,
  output seq_state_t state,
  output logic       hlda,
  output logic       req_ready,
  output logic       accept
);
  seq_state_t state_d;
  logic       hlda_d;
  logic       wr_hold_q, wr_hold_d;
  logic       in_data;
  logic       grant_edge;
  logic       idle_grant;

  assign in_data    = (state == ST_T2) || (state == ST_TW);
  assign grant_edge = in_data && ready && hold;
  assign idle_grant = (state == ST_IDLE) && halt && hold;

  always_comb begin
    req_ready = ((state == ST_IDLE) && !idle_grant) ||
                ((state == ST_HOLD) && !hold);
    accept    = req_valid && req_ready;
  end

  always_comb begin
    state_d   = state;
    hlda_d    = hlda;
    wr_hold_d = wr_hold_q;
    unique case (state)
      ST_IDLE: begin
        if (idle_grant) begin
          state_d = ST_GRANT;
          hlda_d  = 1'b1;
        end else if (accept) begin
          state_d = ST_T1;
        end
      end
      ST_T1: state_d = ST_T2;
      ST_T2, ST_TW: begin
        state_d = ready ? ST_T3 : ST_TW;
        if (grant_edge) begin
          if (cur_write) wr_hold_d = 1'b1;
          else           hlda_d    = 1'b1;
        end
      end
      ST_T3: begin
        wr_hold_d = 1'b0;
        if (hlda) begin
          state_d = ST_HOLD;
        end else if (wr_hold_q) begin
          state_d = ST_GRANT;
          hlda_d  = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_GRANT: state_d = ST_HOLD;
      ST_HOLD: begin
        if (!hold) begin
          hlda_d  = 1'b0;
          state_d = accept ? ST_T1 : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hlda      <= 1'b0;
      wr_hold_q <= 1'b0;
    end else begin
      state     <= state_d;
      hlda      <= hlda_d;
      wr_hold_q <= wr_hold_d;
    end
  end

  AST_HLDA_RISE_POINT: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> ((state == ST_T3) && !cur_write) || (state == ST_GRANT)); // R8

  AST_TW_AFTER_LOW_READY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TW) |-> !$past(ready)); // R5

  AST_T1_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> (state == ST_T1)); // R2

endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive
  import bus_seq_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  STAT_FETCH = 8'hA2,
  parameter logic [7:0]  STAT_MRD   = 8'h82,
  parameter logic [7:0]  STAT_MWR   = 8'h00,
  parameter logic [7:0]  STAT_IN    = 8'h42,
  parameter logic [7:0]  STAT_OUT   = 8'h10,
  parameter logic [7:0]  STAT_INTA  = 8'h23
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state,
  input  logic [2:0]        cur_type,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              sync,
  output logic              dbin,
  output logic              wr_n,
  output logic              wait_st
);
  logic [7:0]        status;
  logic [DATA_W-1:0] status_w;
  logic              is_wr;
  logic              data_phase;
  logic              write_span;

  always_comb begin
    unique case (cur_type)
      CYC_FETCH: status = STAT_FETCH;
      CYC_MWR:   status = STAT_MWR;
      CYC_IN:    status = STAT_IN;
      CYC_OUT:   status = STAT_OUT;
      CYC_INTA:  status = STAT_INTA;
      default:   status = STAT_MRD;
    endcase
  end

  generate
    if (DATA_W > 8) begin : g_stat_wide
      assign status_w = {{(DATA_W-8){1'b0}}, status};
    end else begin : g_stat_narrow
      assign status_w = status[DATA_W-1:0];
    end
  endgenerate

  assign is_wr      = cyc_is_write(cur_type);
  assign data_phase = (state == ST_T2) || (state == ST_TW);
  assign write_span = is_wr && (data_phase || (state == ST_T3));

  always_comb begin
    addr_out = cur_addr;
    addr_oe  = (state != ST_HOLD);
    sync     = (state == ST_T1);
    wait_st  = (state == ST_TW);
    dbin     = !is_wr && data_phase;
    wr_n     = !write_span;
    data_oe  = (state == ST_T1) || write_span;
    data_out = (state == ST_T1) ? status_w : cur_wdata;
  end

  AST_DBIN_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    dbin |-> !data_oe); // R3

  AST_WR_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> data_oe && addr_oe); // R4

  AST_SYNC_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    sync |=> !sync); // R2

endmodule

// File: rtl/bus_seq_rdcap.sv
module bus_seq_rdcap
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state,
  input  logic              cur_write,
  input  logic              ready,
  input  logic [DATA_W-1:0] data_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic take;

  assign take = !cur_write && ready && ((state == ST_T2) || (state == ST_TW));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= take;
      if (take) rd_data <= data_in;
    end
  end

  AST_RDV_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R3

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         DATA_W     = 8,
  parameter int         PORT_W     = 8,
  parameter logic [7:0] STAT_FETCH = 8'hA2,
  parameter logic [7:0] STAT_MRD   = 8'h82,
  parameter logic [7:0] STAT_MWR   = 8'h00,
  parameter logic [7:0] STAT_IN    = 8'h42,
  parameter logic [7:0] STAT_OUT   = 8'h10,
  parameter logic [7:0] STAT_INTA  = 8'h23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready,
  input  logic              hold,
  input  logic              halt,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_oe,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_in,
  output logic              sync,
  output logic              dbin,
  output logic              wr_n,
  output logic              wait_st,
  output logic              hlda,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  seq_state_t        state;
  logic              accept;
  logic [2:0]        cur_type;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_write;

  assign cur_write = cyc_is_write(cur_type);

  bus_seq_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W)) i_latch (
    .clk(clk), .rst(rst), .accept(accept),
    .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
    .cur_type(cur_type), .cur_addr(cur_addr), .cur_wdata(cur_wdata)
  );

  bus_seq_fsm i_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .cur_write(cur_write),
    .ready(ready), .hold(hold), .halt(halt),
    .state(state), .hlda(hlda), .req_ready(req_ready), .accept(accept)
  );

  bus_seq_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_FETCH(STAT_FETCH), .STAT_MRD(STAT_MRD), .STAT_MWR(STAT_MWR),
    .STAT_IN(STAT_IN), .STAT_OUT(STAT_OUT), .STAT_INTA(STAT_INTA)
  ) i_drive (
    .clk(clk), .rst(rst), .state(state), .cur_type(cur_type),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata),
    .addr_out(addr_out), .addr_oe(addr_oe), .data_out(data_out), .data_oe(data_oe),
    .sync(sync), .dbin(dbin), .wr_n(wr_n), .wait_st(wait_st)
  );

  bus_seq_rdcap #(.DATA_W(DATA_W)) i_rdcap (
    .clk(clk), .rst(rst), .state(state), .cur_write(cur_write),
    .ready(ready), .data_in(data_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_WAIT_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    wait_st && !ready |=> wait_st); // R5

  AST_FLOAT_AFTER_HLDA: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |=> !addr_oe && !data_oe); // R9

  AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_n && $past(!wr_n) |-> $stable(data_out)); // R4

  AST_HLDA_IDLE_NO_HALT: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !hlda && !halt) |=> !$rose(hlda)); // R7

endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_type = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        ready = 1'b1;
  logic        hold = 1'b0;
  logic        halt = 1'b0;
  logic [15:0] addr_out;
  logic        addr_oe;
  logic [7:0]  data_out;
  logic        data_oe;
  logic [7:0]  data_in = '0;
  logic        sync, dbin, wr_n, wait_st, hlda, rd_valid;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0]  t;
    logic [15:0] a;
    logic [7:0]  wd;
    logic [7:0]  rd;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  always #4 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
    .ready(ready), .hold(hold), .halt(halt),
    .addr_out(addr_out), .addr_oe(addr_oe), .data_out(data_out), .data_oe(data_oe),
    .data_in(data_in), .sync(sync), .dbin(dbin), .wr_n(wr_n), .wait_st(wait_st),
    .hlda(hlda), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_of(input logic [2:0] t);
    case (t)
      3'd0: return 8'hA2;
      3'd2: return 8'h00;
      3'd3: return 8'h42;
      3'd4: return 8'h10;
      3'd5: return 8'h23;
      default: return 8'h82;
    endcase
  endfunction

  function automatic logic is_wr(input logic [2:0] t);
    return (t == 3'd2) || (t == 3'd4);
  endfunction

  function automatic logic [15:0] addr_of(input logic [2:0] t, input logic [15:0] a);
    return ((t == 3'd3) || (t == 3'd4)) ? {a[7:0], a[7:0]} : a;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (sync) begin
        if (q.size() == 0) begin
          chk("R2 cycle started with no request queued", 1, 0);
        end else begin
          cur = q.pop_front();
          chk("R2 status byte in T1", data_out, stat_of(cur.t));
          chk("R2 data_oe in T1", data_oe, 1);
          chk("R6 address in T1", addr_out, addr_of(cur.t, cur.a));
          chk("R6 addr_oe in T1", addr_oe, 1);
        end
      end
      if (!wr_n) begin
        chk("R4 write data while wr_n low", data_out, cur.wd);
        chk("R4 data_oe while wr_n low", data_oe, 1);
      end
      if (rd_valid) chk("R3 read data", rd_data, cur.rd);
    end
  end

  task automatic run_cycle(input logic [2:0] t, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rd,
                           input int w, input bit hreq);
    exp_t e;
    bit   wrc;
    wrc = is_wr(t);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    e.t = t; e.a = a; e.wd = wd; e.rd = rd;
    q.push_back(e);
    @(negedge clk); // T1
    req_valid = 1'b0;
    ready = (w == 0);
    data_in = rd;
    if (hreq) hold = 1'b1;
    @(negedge clk); // T2
    chk("R3 dbin in T2", dbin, !wrc);
    chk("R4 wr_n in T2", wr_n, !wrc);
    chk("R5 no wait in T2", wait_st, 0);
    for (int j = 1; j <= w; j++) begin
      @(negedge clk); // TW
      chk("R5 wait state asserted", wait_st, 1);
      chk("R3 dbin held in TW", dbin, !wrc);
      chk("R6 address held in TW", addr_out, addr_of(t, a));
      ready = (j == w);
    end
    @(negedge clk); // T3
    chk("R5 T3 reached after ready", wait_st, 0);
    chk("R3 rd_valid in T3", rd_valid, !wrc);
    chk("R3 dbin low in T3", dbin, 0);
    ready = 1'b1;
    if (hreq) begin
      if (!wrc) begin
        chk("R8 hlda in T3 of read", hlda, 1);
        chk("R9 address still driven as hlda rises", addr_oe, 1);
      end else begin
        chk("R8 hlda low in T3 of write", hlda, 0);
        @(negedge clk);
        chk("R8 hlda one clock after T3 of write", hlda, 1);
        chk("R9 address still driven as hlda rises", addr_oe, 1);
        chk("R4 wr_n released after T3", wr_n, 1);
      end
      @(negedge clk);
      chk("R9 address floated", addr_oe, 0);
      chk("R9 data floated", data_oe, 0);
      chk("R9 hlda held", hlda, 1);
      chk("R10 no request taken during hold", req_ready, 0);
      hold = 1'b0;
      @(negedge clk);
      chk("R10 hlda dropped after release", hlda, 0);
      chk("R10 ready for request after release", req_ready, 1);
    end else begin
      @(negedge clk);
      chk("R1 idle after T3", req_ready, 1);
      chk("R7 no hlda without hold", hlda, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 hlda in reset", hlda, 0);
    chk("R1 sync in reset", sync, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 hlda after reset", hlda, 0);
    chk("R1 dbin after reset", dbin, 0);
    chk("R1 wr_n after reset", wr_n, 1);
    chk("R1 wait after reset", wait_st, 0);
    chk("R1 data_oe after reset", data_oe, 0);
    chk("R1 rd_valid after reset", rd_valid, 0);
    chk("R1 req_ready after reset", req_ready, 1);

    run_cycle(3'd0, 16'h1234, 8'h00, 8'h3E, 0, 1'b0);
    run_cycle(3'd1, 16'hBEEF, 8'h00, 8'h5A, 2, 1'b0);
    run_cycle(3'd2, 16'h8001, 8'hC3, 8'h00, 0, 1'b0);
    run_cycle(3'd3, 16'hAB7F, 8'h00, 8'h66, 1, 1'b0);
    run_cycle(3'd4, 16'h0012, 8'h99, 8'h00, 3, 1'b0);
    run_cycle(3'd5, 16'h0000, 8'h00, 8'hFF, 0, 1'b0);
    run_cycle(3'd7, 16'h0F0F, 8'h00, 8'h81, 0, 1'b0);
    run_cycle(3'd1, 16'h2222, 8'h00, 8'h11, 0, 1'b1);
    run_cycle(3'd2, 16'h3333, 8'h4C, 8'h00, 1, 1'b1);
    run_cycle(3'd0, 16'h4444, 8'h00, 8'h77, 2, 1'b1);

    // R7: hold while idle and not halted is ignored
    @(negedge clk);
    hold = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 idle hold not halted: hlda", hlda, 0);
      chk("R7 idle hold not halted: req_ready", req_ready, 1);
      chk("R7 idle hold not halted: address driven", addr_oe, 1);
    end
    hold = 1'b0;

    // R7/R8/R9: halted grant
    @(negedge clk);
    halt = 1'b1; hold = 1'b1;
    @(negedge clk);
    chk("R8 halted grant hlda", hlda, 1);
    chk("R9 address driven in grant clock", addr_oe, 1);
    chk("R7 request blocked during grant", req_ready, 0);
    @(negedge clk);
    chk("R9 halted hold address floated", addr_oe, 0);
    chk("R9 halted hold data floated", data_oe, 0);

    // R10: release with a request pending
    begin
      exp_t e;
      halt = 1'b0; hold = 1'b0;
      req_valid = 1'b1; req_type = 3'd1; req_addr = 16'h4000; req_wdata = 8'h00;
      e.t = 3'd1; e.a = 16'h4000; e.wd = 8'h00; e.rd = 8'hA5;
      q.push_back(e);
      #1;
      chk("R10 request taken on release", req_ready, 1);
      @(negedge clk);
      chk("R10 T1 right after release", sync, 1);
      chk("R10 hlda low in new T1", hlda, 0);
      req_valid = 1'b0; ready = 1'b1; data_in = 8'hA5;
      @(negedge clk);
      @(negedge clk);
      chk("R3 rd_valid after release cycle", rd_valid, 1);
      @(negedge clk);
    end

    // R11: reset during hold
    halt = 1'b1; hold = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 hlda high before reset", hlda, 1);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 reset clears hlda", hlda, 0);
    chk("R11 reset restores address drive", addr_oe, 1);
    halt = 1'b0; hold = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset", req_ready, 1);

    chk("R2 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule